// File: doc/BRIEF.md
# Center-Aligned Complementary PWM with Dead Time

This block drives one high-side and one low-side switch from a single clock. An up/down counter sweeps each switching period: it counts down through the first half to the center, then back up through the second half. The high-side output is active around the center of the period. The low-side output is active around the period boundary. Dead time is removed from both edges of each output's on-time, which leaves a gap in which neither switch is commanded on. Both outputs are active low.

Settings come in on plain input ports: a period count, a signed duty offset and a dead-time count. A one-cycle load strobe captures them into a holding register. The running settings take those values at the start of every period. With double-update selected, they also take them at the center, so the two halves of one period can run with different period, duty or dead-time values. A period setting below 2 parks the block with both outputs off.

Top module: `pwm_ca_gen`

## Requirements
- R1: The half-period length is H = floor(period/2) cycles. In each half, the high-side output is low for clamp(floor(H/2) + duty - dead, 0, H) cycles, where duty is a two's-complement value. In steady state this gives one low pulse per period of twice that length, centered on the midpoint of the period.
- R2: In each half, the low-side output is low for clamp(floor(H/2) - duty - dead, 0, H) cycles. In steady state this gives one low pulse per period of twice that length, centered on the period boundary.
- R3: An on-time that works out negative leaves that output high for the whole half. An on-time that works out at H or more holds that output low for the whole half (100%).
- R4: The two outputs are never low in the same cycle.
- R5: Output level 0 commands a switch on and level 1 commands it off. A period holds the high-side low cycles and the low-side low cycles in the counts of R1 and R2, separated by the dead time.
- R6: A high load strobe captures period, duty and dead into a holding register. With double-update off, the running settings take the held values only at the start of a period. A change therefore mixes old and new values in one low-side pulse but never in a high-side pulse.
- R7: With double-update on, the running settings also take the held values at the center of the period. A change therefore mixes old and new values in one high-side pulse.
- R8: While the running period is below 2, both outputs stay high and the counter stays at zero.
- R9: A synchronous active-low reset clears the counter, the running settings and the holding register. Both outputs stay high until new settings are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_load | input | 1 | Strobe that captures the three settings |
| cfg_period | input | CNT_W | Full switching period in clock cycles |
| cfg_duty | input | CNT_W | Signed duty offset from 50% |
| cfg_dead | input | CNT_W | Dead time in clock cycles, removed from each edge |
| dbl_upd | input | 1 | 1: settings also reload at the center of the period |
| pwm_hi_n | output | 1 | High-side drive, active low |
| pwm_lo_n | output | 1 | Low-side drive, active low |

## Verification
A counter that steps the wrong way, or misses the center turn, shows up within one half-period as a low pulse of the wrong length or in the wrong place. It also makes both outputs go low together in the same cycle. When the running settings reload at the wrong moment, the mixed pulse moves to the wrong output. Single-update then shows a mixed high-side pulse, or double-update shows none, in the first period after a strobe. A clamp fault appears as a partial pulse where a whole half at a fixed level is expected, and it is visible in the first period after the new values take effect.

// File: rtl/pwm_ca_pkg.sv
package pwm_ca_pkg;
   typedef enum logic {
      HALF_FALL = 1'b0,
      HALF_RISE = 1'b1
   } half_e;
endpackage

// File: rtl/pwm_ca_shadow.sv
module pwm_ca_shadow #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] in_period,
   input  logic [CNT_W-1:0] in_duty,
   input  logic [CNT_W-1:0] in_dead,
   output logic [CNT_W-1:0] sh_period,
   output logic [CNT_W-1:0] sh_duty,
   output logic [CNT_W-1:0] sh_dead
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_period <= '0;
         sh_duty   <= '0;
         sh_dead   <= '0;
      end else if (load) begin
         sh_period <= in_period;
         sh_duty   <= in_duty;
         sh_dead   <= in_dead;
      end
   end
endmodule

// File: rtl/pwm_ca_ontime.sv
module pwm_ca_ontime #(
   parameter int CNT_W = 12
) (
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] duty,
   input  logic [CNT_W-1:0] dead,
   output logic [CNT_W-1:0] half_len,
   output logic [CNT_W-1:0] on_hi,
   output logic [CNT_W-1:0] on_lo
);
   localparam int EW = CNT_W + 2;

   logic signed [EW-1:0] half_s, quart_s, duty_s, dead_s;
   logic [CNT_W-1:0]     on_t [2];

   assign half_len = period >> 1;
   assign half_s   = signed'({2'b00, half_len});
   assign quart_s  = signed'({3'b000, half_len[CNT_W-1:1]});
   assign duty_s   = signed'({{2{duty[CNT_W-1]}}, duty});
   assign dead_s   = signed'({2'b00, dead});

   // side 0 = high side (duty added), side 1 = low side (duty subtracted)
   for (genvar s = 0; s < 2; s++) begin : g_side
      logic signed [EW-1:0] raw;
      assign raw = (s == 0) ? (quart_s + duty_s - dead_s)
                            : (quart_s - duty_s - dead_s);
      always_comb begin
         if (raw < 0)
            on_t[s] = '0;
         else if (raw > half_s)
            on_t[s] = half_len;
         else
            on_t[s] = raw[CNT_W-1:0];
      end
   end

   assign on_hi = on_t[0];
   assign on_lo = on_t[1];
endmodule

// File: rtl/pwm_ca_core.sv
module pwm_ca_core
   import pwm_ca_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dbl,
   input  logic [CNT_W-1:0] nx_half,
   input  logic [CNT_W-1:0] nx_on_hi,
   input  logic [CNT_W-1:0] nx_on_lo,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] half_act,
   output logic [CNT_W-1:0] on_hi_act,
   output logic [CNT_W-1:0] on_lo_act,
   output half_e            phase,
   output logic             run
);
   logic at_end, at_mid;

   assign run    = (half_act != '0);
   assign at_end = run && (phase == HALF_RISE) && (cnt == half_act - 1'b1);
   assign at_mid = run && (phase == HALF_FALL) && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         half_act  <= '0;
         on_hi_act <= '0;
         on_lo_act <= '0;
         phase     <= HALF_FALL;
      end else if (!run || at_end) begin
         half_act  <= nx_half;
         on_hi_act <= nx_on_hi;
         on_lo_act <= nx_on_lo;
         cnt       <= (nx_half == '0) ? '0 : nx_half - 1'b1;
         phase     <= HALF_FALL;
      end else if (at_mid) begin
         phase <= HALF_RISE;
         cnt   <= '0;
         if (dbl) begin
            half_act  <= nx_half;
            on_hi_act <= nx_on_hi;
            on_lo_act <= nx_on_lo;
         end
      end else if (phase == HALF_FALL) begin
         cnt <= cnt - 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pwm_ca_outdec.sv
module pwm_ca_outdec #(
   parameter int CNT_W   = 12,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] half_len,
   input  logic [CNT_W-1:0] on_hi,
   input  logic [CNT_W-1:0] on_lo,
   output logic             hi_n,
   output logic             lo_n
);
   logic hi_on, lo_on;

   assign hi_on = run && (cnt < on_hi);
   assign lo_on = run && (cnt >= half_len - on_lo);

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hi_n <= 1'b1;
            lo_n <= 1'b1;
         end else begin
            hi_n <= !hi_on;
            lo_n <= !lo_on;
         end
      end
   end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign hi_n = !hi_on;
      assign lo_n = !lo_on;
   end
endmodule

// File: rtl/pwm_ca_gen.sv
module pwm_ca_gen
   import pwm_ca_pkg::*;
#(
   parameter int CNT_W   = 12,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_load,
   input  logic [CNT_W-1:0] cfg_period,
   input  logic [CNT_W-1:0] cfg_duty,
   input  logic [CNT_W-1:0] cfg_dead,
   input  logic             dbl_upd,
   output logic             pwm_hi_n,
   output logic             pwm_lo_n
);
   if (CNT_W < 4) begin : g_bad_width
      $error("pwm_ca_gen: CNT_W must be at least 4");
   end

   logic [CNT_W-1:0] sh_period, sh_duty, sh_dead;
   logic [CNT_W-1:0] nx_half, nx_on_hi, nx_on_lo;
   logic [CNT_W-1:0] cnt, half_act, on_hi_act, on_lo_act;
   half_e            phase;
   logic             run;

   pwm_ca_shadow #(.CNT_W(CNT_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .load(cfg_load),
      .in_period(cfg_period), .in_duty(cfg_duty), .in_dead(cfg_dead),
      .sh_period(sh_period), .sh_duty(sh_duty), .sh_dead(sh_dead)
   );

   pwm_ca_ontime #(.CNT_W(CNT_W)) u_ontime (
      .period(sh_period), .duty(sh_duty), .dead(sh_dead),
      .half_len(nx_half), .on_hi(nx_on_hi), .on_lo(nx_on_lo)
   );

   pwm_ca_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .dbl(dbl_upd),
      .nx_half(nx_half), .nx_on_hi(nx_on_hi), .nx_on_lo(nx_on_lo),
      .cnt(cnt), .half_act(half_act), .on_hi_act(on_hi_act),
      .on_lo_act(on_lo_act), .phase(phase), .run(run)
   );

   pwm_ca_outdec #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_outdec (
      .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .half_len(half_act),
      .on_hi(on_hi_act), .on_lo(on_lo_act),
      .hi_n(pwm_hi_n), .lo_n(pwm_lo_n)
   );
endmodule

// File: rtl/pwm_ca_chk.sv
module pwm_ca_chk
   import pwm_ca_pkg::*;
#(
   parameter int CNT_W   = 12,
   parameter bit OUT_REG = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dbl_upd,
   input logic             pwm_hi_n,
   input logic             pwm_lo_n,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] half_act,
   input half_e            phase
);
   // R4
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_hi_n || pwm_lo_n));

   // R5
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (half_act != '0) |-> (cnt < half_act));

   // R7
   mid_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((half_act != '0) && (phase == HALF_FALL) && (cnt == '0))
      |=> ((phase == HALF_RISE) && (cnt == '0)));

   // R6
   single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((half_act != '0) && !dbl_upd &&
       !((phase == HALF_RISE) && (cnt == half_act - 1'b1)))
      |=> $stable(half_act));

   if (OUT_REG) begin : g_idle_reg
      // R8
      idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (half_act == '0) |=> (pwm_hi_n && pwm_lo_n));
   end else begin : g_idle_comb
      // R8
      idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (half_act == '0) |-> (pwm_hi_n && pwm_lo_n && (cnt == '0)));
   end
endmodule

bind pwm_ca_gen pwm_ca_chk #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .dbl_upd(dbl_upd),
   .pwm_hi_n(pwm_hi_n), .pwm_lo_n(pwm_lo_n),
   .cnt(cnt), .half_act(half_act), .phase(phase)
);

// File: tb/tb_pwm_ca_gen.sv
`timescale 1ns/1ps
module tb_pwm_ca_gen;
   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_load = 1'b0;
   logic [W-1:0] cfg_period = '0;
   logic [W-1:0] cfg_duty = '0;
   logic [W-1:0] cfg_dead = '0;
   logic         dbl_upd = 1'b0;
   logic         pwm_hi_n, pwm_lo_n;

   int checks = 0;
   int errors = 0;
   int overlaps = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pwm_ca_gen #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
      .cfg_period(cfg_period), .cfg_duty(cfg_duty), .cfg_dead(cfg_dead),
      .dbl_upd(dbl_upd), .pwm_hi_n(pwm_hi_n), .pwm_lo_n(pwm_lo_n)
   );

   always @(negedge clk)
      if (rst_n && !pwm_hi_n && !pwm_lo_n) overlaps++;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic load_cfg(input int p, input int d, input int dt);
      @(negedge clk);
      cfg_period = W'(p); cfg_duty = W'(d); cfg_dead = W'(dt);
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   function automatic logic sig(input bit lo_side);
      return lo_side ? pwm_lo_n : pwm_hi_n;
   endfunction

   // length of the next complete low pulse on one output
   task automatic pulse_width(input bit lo_side, output int w);
      int g = 0;
      w = 0;
      while (sig(lo_side) == 1'b0 && g < 4000) begin @(negedge clk); g++; end
      while (sig(lo_side) == 1'b1 && g < 4000) begin @(negedge clk); g++; end
      while (sig(lo_side) == 1'b0 && g < 4000) begin @(negedge clk); g++; w++; end
   endtask

   task automatic window_cnt(input int n, output int ch, output int cl);
      ch = 0; cl = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (!pwm_hi_n) ch++;
         if (!pwm_lo_n) cl++;
      end
   endtask

   // waits for a low-side pulse to end, then strobes new settings at once
   task automatic strobe_after_lo(input int p, input int d, input int dt);
      int g = 0;
      while (pwm_lo_n == 1'b1 && g < 4000) begin @(negedge clk); g++; end
      while (pwm_lo_n == 1'b0 && g < 4000) begin @(negedge clk); g++; end
      cfg_period = W'(p); cfg_duty = W'(d); cfg_dead = W'(dt);
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   task automatic t_reset_state();
      int ch, cl;
      window_cnt(10, ch, cl);
      chk("R9 reset hi", ch, 0);
      chk("R9 reset lo", cl, 0);
   endtask

   // P=40 -> H=20, duty 3, dead 2: hi 11/half, lo 5/half
   task automatic t_steady();
      int w, ch, cl;
      dbl_upd = 1'b0;
      load_cfg(40, 3, 2);
      cycles(160);
      pulse_width(1'b0, w); chk("R1 hi pulse", w, 22);
      pulse_width(1'b1, w); chk("R2 lo pulse", w, 10);
      window_cnt(40, ch, cl);
      chk("R5 hi low per period", ch, 22);
      chk("R5 lo low per period", cl, 10);
   endtask

   // B: duty -4, dead 1: hi 5/half, lo 13/half
   task automatic t_single_switch();
      int w;
      strobe_after_lo(40, -4, 1);
      pulse_width(1'b0, w); chk("R6 hi pulse keeps old", w, 22);
      pulse_width(1'b1, w); chk("R6 lo pulse mixes", w, 18);
      pulse_width(1'b0, w); chk("R6 hi pulse new", w, 10);
   endtask

   task automatic t_double_switch();
      int w;
      dbl_upd = 1'b1;
      load_cfg(40, 3, 2);
      cycles(200);
      pulse_width(1'b0, w); chk("R7 hi steady", w, 22);
      strobe_after_lo(40, -4, 1);
      pulse_width(1'b0, w); chk("R7 hi pulse mixes", w, 16);
      pulse_width(1'b1, w); chk("R7 lo pulse new", w, 26);
      pulse_width(1'b0, w); chk("R7 hi pulse new", w, 10);
      dbl_upd = 1'b0;
   endtask

   task automatic t_half_duty();
      int w, ch, cl;
      load_cfg(24, 0, 0);
      cycles(200);
      pulse_width(1'b0, w); chk("R1 hi 50%", w, 12);
      pulse_width(1'b1, w); chk("R2 lo 50%", w, 12);
      window_cnt(48, ch, cl);
      chk("R5 no gap total", ch + cl, 48);
   endtask

   // P=20 -> H=10
   task automatic t_clamp();
      int ch, cl;
      load_cfg(20, 9, 0);
      cycles(200);
      window_cnt(40, ch, cl);
      chk("R3 hi full", ch, 40);
      chk("R3 lo none", cl, 0);
      load_cfg(20, -8, 3);
      cycles(200);
      window_cnt(40, ch, cl);
      chk("R3 hi negative none", ch, 0);
      chk("R3 lo full", cl, 40);
   endtask

   task automatic t_idle();
      int ch, cl;
      load_cfg(1, 0, 0);
      cycles(200);
      window_cnt(40, ch, cl);
      chk("R8 period 1 hi", ch, 0);
      chk("R8 period 1 lo", cl, 0);
      load_cfg(0, 2, 0);
      cycles(50);
      window_cnt(40, ch, cl);
      chk("R8 period 0 both", ch + cl, 0);
   endtask

   task automatic t_reset_mid();
      int ch, cl;
      load_cfg(40, 3, 2);
      cycles(200);
      @(negedge clk); rst_n = 1'b0;
      cycles(2);
      rst_n = 1'b1;
      window_cnt(80, ch, cl);
      chk("R9 mid reset hi", ch, 0);
      chk("R9 mid reset lo", cl, 0);
   endtask

   initial begin
      cycles(4);
      rst_n = 1'b1;
      t_reset_state();
      t_steady();
      t_single_switch();
      t_double_switch();
      t_half_duty();
      t_clamp();
      t_idle();
      t_reset_mid();
      chk("R4 overlap cycles", overlaps, 0);
      finish_run();
   end
endmodule